// File: doc/BRIEF.md
# Lockable system status register file

This block is a bank of board-level control and status registers on a simple 32-bit register bus. Addresses are byte offsets, and only whole words are decoded. The bank holds several kinds of register. It has a fixed identity word and a read/write LED register. It has a lock register that opens a protected reset-control register only when a 16-bit key is present. There are two flag words, each with its own set address and clear address; one is cleared by reset and the other is not. A display control register has writable bits that depend on the board variant. A card status register mirrors two input lines, and a free-running counter advances on an enable input.

A single parameter, `VARIANT`, selects one of four board flavours. Variant 0 is the older board with a display mux, and variant 1 is the older board without the mux. Variant 2 is the newer board with reset control, and variant 3 is the minimal board. The variant changes several things: which bit of a reset-control write requests a system reset, which display bits are kept on a write, where the write-protect bit sits, and whether some registers exist at all.

Each bus request is answered one cycle later with `rsp_ready` high. A read returns the register contents as they stood when the request was taken. The system reset request leaves the block as a one-cycle pulse.

Top module: `sysreg_bank`

## Requirements
- R1: Offset 0x00 reads `ID_WORD` and ignores writes. Offset 0x44 always reads 0x00000001.
- R2: Offset 0x08 is a 32-bit read/write LED register that resets to 0.
- R3: A write to the lock register (0x20) has two outcomes. If the full 32-bit data equals 0x0000A05F, the lock stores 0xA05F. Otherwise it stores the data ANDed with 0x7FFF. Reads return the stored 16-bit value, zero-extended. The bank is unlocked only while the stored value is 0xA05F. The lock resets to 0.
- R4: Offset 0x30 reads the flags. A write to 0x30 ORs the data into the flags. A write to 0x34 clears each flag bit that is 1 in the data.
- R5: The non-volatile flags read at 0x38. They are set through 0x38 and cleared through 0x3C. Reset does not change them, while LEDs, lock, flags and reset control all reset to 0.
- R6: A write to reset control (0x40) while the bank is locked changes nothing and raises no reset request.
- R7: In variants 0 and 2, an unlocked write to 0x40 stores the data, and the stored value reads back at 0x40. The write raises `sys_reset_req` for exactly one cycle, in the cycle after the write. The request is raised only when the trigger bit is set in the data: bit 8 in variant 0, bit 2 in variant 2.
- R8: In variants 1 and 3, offset 0x40 reads 0 and never raises a reset request.
- R9: The display register (0x50) resets to 0x00001F00 in variants 0 to 2 and to 0 in variant 3. A write keeps some bits and takes the rest from the data. Variants 0 and 1 keep bits 13:8. Variant 2 keeps only bit 7. Variant 3 keeps all bits, so the register stays 0.
- R10: In variant 0, `mux_sel` equals display bits 1:0. In all other variants it is 0.
- R11: The card register (0x48) reads `card_detect` in bit 0 and `write_prot` in bit 2 (variants 0 and 1) or in bit 1 (variants 2 and 3). All other bits read 0, the register ignores writes, and it follows the input levels with one cycle of delay.
- R12: Offset 0x5C reads a counter that resets to 0 and advances by one in each cycle with `cnt_tick` high.
- R13: Unmapped or reserved offsets (for example 0x04, 0x24, 0x100, 0xFFC) read 0 and ignore writes.
- R14: `rsp_ready` is high in exactly the cycles that follow a cycle with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | Response valid, one cycle after a request |
| rsp_rdata | output | 32 | Read data of the previous read request |
| card_detect | input | 1 | Card present level |
| write_prot | input | 1 | Card write-protect level |
| cnt_tick | input | 1 | Counter advance enable |
| mux_sel | output | 2 | Display format mux select |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
All four variants run side by side on one shared bus, so a single write is checked against four different expected results.

The lock tests try a near-key value, 0x0001A05F, which must not unlock the bank. A design that compares only the low 16 bits would open reset control with that value and pulse the reset line. Reset-control writes are swept over data with only bit 8, only bit 2, or both set. A design that picks the wrong trigger bit, or ignores the lock, either pulses on the wrong variant or stores a value that should have been dropped. The reset line is also checked to fall again after one cycle.

A reset is applied between flag writes to catch a design that clears the non-volatile word along with the rest. The display tests write all-ones, all-zeros and mixed patterns, which expose a wrong keep mask in any variant. All four combinations of the card inputs are swept, so a write-protect bit in the wrong position shows up.

// File: rtl/sysreg_bank.sv
module sysreg_bank #(
  parameter int          VARIANT = 0,
  parameter logic [31:0] ID_WORD = 32'h0190_0000,
  parameter int          ADDR_W  = 12,
  parameter int          CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  input  logic              card_detect,
  input  logic              write_prot,
  input  logic              cnt_tick,
  output logic [1:0]        mux_sel,
  output logic              sys_reset_req
);

  localparam logic [15:0] KEY       = 16'hA05F;
  localparam bit          HAS_RST   = (VARIANT == 0) || (VARIANT == 2);
  localparam bit          HAS_MUX   = (VARIANT == 0);
  localparam logic [31:0] RST_TRIG  = (VARIANT == 0) ? 32'h0000_0100 :
                                      (VARIANT == 2) ? 32'h0000_0004 : 32'h0;
  localparam logic [31:0] DISP_KEEP = (VARIANT < 2)  ? 32'h0000_3F00 :
                                      (VARIANT == 2) ? 32'h0000_0080 : 32'hFFFF_FFFF;
  localparam logic [31:0] DISP_INIT = (VARIANT == 3) ? 32'h0 : 32'h0000_1F00;
  localparam int          WP_BIT    = (VARIANT < 2) ? 2 : 1;

  localparam logic [ADDR_W-1:0] O_ID    = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] O_LED   = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] O_LOCK  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] O_FSET  = ADDR_W'('h30);
  localparam logic [ADDR_W-1:0] O_FCLR  = ADDR_W'('h34);
  localparam logic [ADDR_W-1:0] O_NSET  = ADDR_W'('h38);
  localparam logic [ADDR_W-1:0] O_NCLR  = ADDR_W'('h3C);
  localparam logic [ADDR_W-1:0] O_RCTL  = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] O_ONE   = ADDR_W'('h44);
  localparam logic [ADDR_W-1:0] O_CARD  = ADDR_W'('h48);
  localparam logic [ADDR_W-1:0] O_DISP  = ADDR_W'('h50);
  localparam logic [ADDR_W-1:0] O_CNT   = ADDR_W'('h5C);

  logic [ADDR_W-1:0] word;
  logic              wr, rd, unlocked;
  logic [31:0]       led_q, flag_q, nv_q, rctl_q, disp_q, rd_mux;
  logic [15:0]       lock_q;
  logic [2:0]        card_q, card_nx;
  logic [CNT_W-1:0]  cnt_q;

  assign word     = {req_addr[ADDR_W-1:2], 2'b00};
  assign wr       = req_valid && req_write;
  assign rd       = req_valid && !req_write;
  assign unlocked = (lock_q == KEY);
  assign mux_sel  = HAS_MUX ? disp_q[1:0] : 2'b00;

  always_comb begin
    card_nx         = 3'b000;
    card_nx[0]      = card_detect;
    card_nx[WP_BIT] = write_prot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q         <= '0;
      lock_q        <= '0;
      flag_q        <= '0;
      rctl_q        <= '0;
      disp_q        <= DISP_INIT;
      card_q        <= '0;
      cnt_q         <= '0;
      sys_reset_req <= 1'b0;
      rsp_ready     <= 1'b0;
      rsp_rdata     <= '0;
    end else begin
      card_q        <= card_nx;
      rsp_ready     <= req_valid;
      sys_reset_req <= 1'b0;
      if (cnt_tick) cnt_q <= cnt_q + 1'b1;
      if (rd) rsp_rdata <= rd_mux;
      if (wr) begin
        case (word)
          O_LED:  led_q  <= req_wdata;
          O_LOCK: lock_q <= (req_wdata == {16'h0, KEY}) ? KEY : (req_wdata[15:0] & 16'h7FFF);
          O_FSET: flag_q <= flag_q | req_wdata;
          O_FCLR: flag_q <= flag_q & ~req_wdata;
          O_RCTL: if (HAS_RST && unlocked) begin
                    rctl_q        <= req_wdata;
                    sys_reset_req <= |(req_wdata & RST_TRIG);
                  end
          O_DISP: disp_q <= (disp_q & DISP_KEEP) | (req_wdata & ~DISP_KEEP);
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr && word == O_NSET) nv_q <= nv_q | req_wdata;
    if (wr && word == O_NCLR) nv_q <= nv_q & ~req_wdata;
  end

  always_comb begin
    case (word)
      O_ID:   rd_mux = ID_WORD;
      O_LED:  rd_mux = led_q;
      O_LOCK: rd_mux = {16'h0, lock_q};
      O_FSET: rd_mux = flag_q;
      O_NSET: rd_mux = nv_q;
      O_RCTL: rd_mux = HAS_RST ? rctl_q : 32'h0;
      O_ONE:  rd_mux = 32'h1;
      O_CARD: rd_mux = {29'h0, card_q};
      O_DISP: rd_mux = disp_q;
      O_CNT:  rd_mux = 32'(cnt_q);
      default: rd_mux = 32'h0;
    endcase
  end

  a_r14_ready_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ready);
  a_r14_no_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ready);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req);
  a_r6_pulse_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset_req) |-> $past(unlocked && wr));
  a_r9_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((disp_q & DISP_KEEP) == (DISP_INIT & DISP_KEEP)));

endmodule

// File: tb/test_sysreg_bank.sv
`timescale 1ns/1ps
module test_sysreg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        card_detect = 1'b0, write_prot = 1'b0, cnt_tick = 1'b0;
  logic        rdy [4];
  logic [31:0] rdat [4];
  logic [1:0]  mux [4];
  logic        rreq [4];
  logic [31:0] got [4];
  logic        pulse [4], pulse2 [4];
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar v = 0; v < 4; v++) begin : g_var
    sysreg_bank #(.VARIANT(v), .ID_WORD(32'h0190_0000 + v)) i_sysreg_bank (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rdy[v]),
      .rsp_rdata(rdat[v]), .card_detect(card_detect), .write_prot(write_prot),
      .cnt_tick(cnt_tick), .mux_sel(mux[v]), .sys_reset_req(rreq[v]));
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_all(input logic [11:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    for (int v = 0; v < 4; v++) begin
      got[v] = rdat[v];
      check($sformatf("R14 ready v%0d", v), 32'(rdy[v]), 32'h1);
    end
    req_valid = 1'b0;
  endtask

  task automatic wr_all(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    for (int v = 0; v < 4; v++) pulse[v] = rreq[v];
    req_valid = 1'b0;
    @(negedge clk);
    for (int v = 0; v < 4; v++) pulse2[v] = rreq[v];
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] keep_of(input int v);
    return (v < 2) ? 32'h3F00 : (v == 2) ? 32'h80 : 32'hFFFF_FFFF;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] disp_m [4];
    logic [31:0] c0 [4];
    logic [31:0] pats [6];
    pats = '{32'hFFFF_FFFF, 32'h0, 32'h0000_0002, 32'hA5A5_5A5A, 32'h0000_3F83, 32'h1234_C0FF};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 4; v++) begin
      check($sformatf("R14 idle ready v%0d", v), 32'(rdy[v]), 32'h0);
      check($sformatf("R10 reset mux v%0d", v), 32'(mux[v]), 32'h0);
      check($sformatf("R7 reset req v%0d", v), 32'(rreq[v]), 32'h0);
    end

    rd_all(12'h000);
    for (int v = 0; v < 4; v++) check($sformatf("R1 id v%0d", v), got[v], 32'h0190_0000 + v);
    @(negedge clk);
    for (int v = 0; v < 4; v++) check($sformatf("R14 ready drop v%0d", v), 32'(rdy[v]), 32'h0);
    wr_all(12'h000, 32'hDEAD_BEEF);
    rd_all(12'h000);
    for (int v = 0; v < 4; v++) check($sformatf("R1 id after write v%0d", v), got[v], 32'h0190_0000 + v);
    rd_all(12'h044);
    for (int v = 0; v < 4; v++) check($sformatf("R1 one v%0d", v), got[v], 32'h1);

    rd_all(12'h008);
    for (int v = 0; v < 4; v++) check($sformatf("R2 led reset v%0d", v), got[v], 32'h0);
    for (int p = 0; p < 6; p++) begin
      wr_all(12'h008, pats[p]);
      rd_all(12'h008);
      for (int v = 0; v < 4; v++) check($sformatf("R2 led v%0d", v), got[v], pats[p]);
    end

    rd_all(12'h020);
    for (int v = 0; v < 4; v++) check($sformatf("R3 lock reset v%0d", v), got[v], 32'h0);
    wr_all(12'h020, 32'h1234_FFFF);
    rd_all(12'h020);
    for (int v = 0; v < 4; v++) check($sformatf("R3 lock masked v%0d", v), got[v], 32'h7FFF);
    wr_all(12'h020, 32'h0001_A05F);
    rd_all(12'h020);
    for (int v = 0; v < 4; v++) check($sformatf("R3 near key v%0d", v), got[v], 32'h205F);

    wr_all(12'h040, 32'h0000_0104);
    for (int v = 0; v < 4; v++) check($sformatf("R6 locked no pulse v%0d", v), 32'(pulse[v]), 32'h0);
    rd_all(12'h040);
    for (int v = 0; v < 4; v++) check($sformatf("R6 locked no store v%0d", v), got[v], 32'h0);

    wr_all(12'h020, 32'h0000_A05F);
    rd_all(12'h020);
    for (int v = 0; v < 4; v++) check($sformatf("R3 key v%0d", v), got[v], 32'hA05F);
    for (int t = 0; t < 3; t++) begin
      logic [31:0] d;
      d = (t == 0) ? 32'h104 : (t == 1) ? 32'h100 : 32'h004;
      wr_all(12'h040, d);
      for (int v = 0; v < 4; v++) begin
        logic [31:0] trig;
        trig = (v == 0) ? 32'h100 : (v == 2) ? 32'h4 : 32'h0;
        check($sformatf("R7 R8 pulse v%0d d=%h", v, d), 32'(pulse[v]), 32'((d & trig) != 0));
        check($sformatf("R7 pulse one cycle v%0d", v), 32'(pulse2[v]), 32'h0);
      end
      rd_all(12'h040);
      for (int v = 0; v < 4; v++)
        check($sformatf("R7 R8 rctl read v%0d", v), got[v], (v == 0 || v == 2) ? d : 32'h0);
    end

    wr_all(12'h030, 32'hF0F0);
    wr_all(12'h030, 32'h0F00);
    rd_all(12'h030);
    for (int v = 0; v < 4; v++) check($sformatf("R4 set v%0d", v), got[v], 32'hFFF0);
    wr_all(12'h034, 32'h00F0);
    rd_all(12'h030);
    for (int v = 0; v < 4; v++) check($sformatf("R4 clear v%0d", v), got[v], 32'hFF00);
    wr_all(12'h03C, 32'hFFFF_FFFF);
    wr_all(12'h038, 32'h8001_0003);
    wr_all(12'h03C, 32'h0000_0001);
    rd_all(12'h038);
    for (int v = 0; v < 4; v++) check($sformatf("R5 nv set clear v%0d", v), got[v], 32'h8001_0002);

    wr_all(12'h050, 32'h5);
    do_reset();
    rd_all(12'h038);
    for (int v = 0; v < 4; v++) check($sformatf("R5 nv kept v%0d", v), got[v], 32'h8001_0002);
    rd_all(12'h030);
    for (int v = 0; v < 4; v++) check($sformatf("R5 flags cleared v%0d", v), got[v], 32'h0);
    rd_all(12'h020);
    for (int v = 0; v < 4; v++) check($sformatf("R5 lock cleared v%0d", v), got[v], 32'h0);
    rd_all(12'h008);
    for (int v = 0; v < 4; v++) check($sformatf("R5 led cleared v%0d", v), got[v], 32'h0);
    rd_all(12'h040);
    for (int v = 0; v < 4; v++) check($sformatf("R5 rctl cleared v%0d", v), got[v], 32'h0);

    rd_all(12'h050);
    for (int v = 0; v < 4; v++) begin
      disp_m[v] = (v == 3) ? 32'h0 : 32'h1F00;
      check($sformatf("R9 disp reset v%0d", v), got[v], disp_m[v]);
    end
    for (int p = 0; p < 6; p++) begin
      wr_all(12'h050, pats[p]);
      for (int v = 0; v < 4; v++) begin
        disp_m[v] = (disp_m[v] & keep_of(v)) | (pats[p] & ~keep_of(v));
        check($sformatf("R10 mux v%0d", v), 32'(mux[v]), (v == 0) ? (disp_m[v] & 32'h3) : 32'h0);
      end
      rd_all(12'h050);
      for (int v = 0; v < 4; v++) check($sformatf("R9 disp v%0d p%0d", v, p), got[v], disp_m[v]);
    end

    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      card_detect = c[0]; write_prot = c[1];
      wr_all(12'h048, 32'hFFFF_FFFF);
      rd_all(12'h048);
      for (int v = 0; v < 4; v++)
        check($sformatf("R11 card v%0d c%0d", v, c), got[v],
              32'(c[0]) | (32'(c[1]) << ((v < 2) ? 2 : 1)));
    end

    @(negedge clk); cnt_tick = 1'b1;
    rd_all(12'h05C);
    for (int v = 0; v < 4; v++) c0[v] = got[v];
    repeat (10) @(negedge clk);
    rd_all(12'h05C);
    for (int v = 0; v < 4; v++) check($sformatf("R12 count delta v%0d", v), got[v] - c0[v], 32'd12);
    @(negedge clk); cnt_tick = 1'b0;
    rd_all(12'h05C);
    for (int v = 0; v < 4; v++) c0[v] = got[v];
    repeat (7) @(negedge clk);
    rd_all(12'h05C);
    for (int v = 0; v < 4; v++) check($sformatf("R12 count hold v%0d", v), got[v], c0[v]);

    for (int k = 0; k < 4; k++) begin
      logic [11:0] a;
      a = (k == 0) ? 12'h004 : (k == 1) ? 12'h024 : (k == 2) ? 12'h100 : 12'hFFC;
      wr_all(a, 32'hFFFF_FFFF);
      rd_all(a);
      for (int v = 0; v < 4; v++) check($sformatf("R13 unmapped v%0d a=%h", v, a), got[v], 32'h0);
    end
    rd_all(12'h008);
    for (int v = 0; v < 4; v++) check($sformatf("R13 led untouched v%0d", v), got[v], 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule